// File: doc/BRIEF.md
# Ternary Bitwise Lookup Unit

This unit applies any one of the 256 Boolean functions of three inputs to three 64-bit words, one bit position at a time. At each position the bits of the three operands form a 3-bit index, and that index picks one bit out of an 8-bit truth table. The truth table is the whole operation code. A multiplexer, a majority vote, a parity, a conditional mix or any other three-input function is chosen by the table value alone, with no fixed opcode for each function.

The truth table comes from one of two sources. The first is an immediate that the instruction word holds in two pieces. The second is the low byte of a fourth register. A word mode changes the meaning of the index. Each operand as a whole is reduced to zero or nonzero, and the single looked-up bit is returned as the integer 0 or 1. The lookup is combinational and feeds one output register, so a result appears one clock after its inputs are presented as valid. The first operand is the old value of the destination. The caller feeds that value back into this input.

Top module: `tlut_unit`

## Requirements
- R1: In bitwise mode, result bit i equals table bit number {opd_a[i], opd_b[i], opd_c[i]}, where opd_a supplies index bit 2, opd_b index bit 1 and opd_c index bit 0.
- R2: When tbl_from_reg is 0, the table is {imm_hi, imm_lo}: imm_lo gives table bits 0 to 4 and imm_hi gives table bits 5 to 7.
- R3: When tbl_from_reg is 1, the table is tbl_reg[7:0], and tbl_reg[63:8] has no effect on the result.
- R4: In word mode (mode = 1), result[0] equals table bit number {|opd_a, |opd_b, |opd_c}, and result[63:1] is zero.
- R5: Mode values 2 and 3 give exactly the bitwise-mode result.
- R6: Table value 0xD8 gives (opd_b & opd_c) | (opd_a & ~opd_c) for any operands.
- R7: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low. The result of that input set is on result from that same cycle.
- R8: While in_valid is low, result keeps its last value whatever the other inputs do.
- R9: While reset is asserted, out_valid and result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| opd_a | input | 64 | First operand, old destination value, index bit 2 |
| opd_b | input | 64 | Second operand, index bit 1 |
| opd_c | input | 64 | Third operand, index bit 0 |
| imm_lo | input | 5 | Immediate table bits 0 to 4 |
| imm_hi | input | 3 | Immediate table bits 5 to 7 |
| tbl_reg | input | 64 | Register table source; only bits 7:0 used |
| tbl_from_reg | input | 1 | 1 selects tbl_reg as table, 0 the immediate |
| mode | input | 2 | 0 bitwise, 1 whole-word zero/nonzero, 2 and 3 act as bitwise |
| out_valid | output | 1 | result holds a new value |
| result | output | 64 | Registered lookup result |

## Verification
All 256 table values are swept in both bitwise and word mode. Each table is tried against all-zero operands, all-one operands, random operands and a mix of constant and random words. The constant words reach only table bit 0 or bit 7, so they show whether the two immediate pieces are joined in the right order. Random operands reach every index and expose a swapped operand-to-index assignment. In word mode every zero/nonzero combination is formed from operands that have a single bit set. This separates a whole-word reduction from a bitwise test of bit 0. Random upper bits on the table register, reserved mode values and a pause in in_valid while the inputs keep changing show that these inputs do not leak into the result.

// File: rtl/tlut_pkg.sv
package tlut_pkg;
  localparam int IDX_W = 3;
  localparam int TBL_W = 1 << IDX_W;

  typedef enum logic [1:0] {
    LM_BITWISE = 2'd0,
    LM_WORD    = 2'd1,
    LM_RSVD_A  = 2'd2,
    LM_RSVD_B  = 2'd3
  } lut_mode_e;
endpackage

// File: rtl/tlut_table_sel.sv
module tlut_table_sel #(
  parameter int REG_W = 64,
  parameter int LO_W  = 5,
  parameter int HI_W  = 3
) (
  input  logic [LO_W-1:0]      imm_lo,
  input  logic [HI_W-1:0]      imm_hi,
  input  logic [REG_W-1:0]     tbl_reg,
  input  logic                 from_reg,
  output logic [LO_W+HI_W-1:0] table_o
);
  localparam int TW = LO_W + HI_W;

  logic [TW-1:0] imm_tbl;
  logic [TW-1:0] reg_tbl;

  // low piece lands in the low table bits, high piece above it
  assign imm_tbl = {imm_hi, imm_lo};
  assign reg_tbl = TW'(tbl_reg);

  always_comb begin
    if (from_reg) table_o = reg_tbl;
    else          table_o = imm_tbl;
  end
endmodule

// File: rtl/tlut_bitwise.sv
module tlut_bitwise #(
  parameter int W = 64
) (
  input  logic [W-1:0]              a,
  input  logic [W-1:0]              b,
  input  logic [W-1:0]              c,
  input  logic [tlut_pkg::TBL_W-1:0] tbl,
  output logic [W-1:0]              y
);
  import tlut_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [IDX_W-1:0] idx;
    assign idx  = {a[i], b[i], c[i]};
    assign y[i] = tbl[idx];
  end
endmodule

// File: rtl/tlut_wordtest.sv
module tlut_wordtest #(
  parameter int W = 64
) (
  input  logic [W-1:0]              a,
  input  logic [W-1:0]              b,
  input  logic [W-1:0]              c,
  input  logic [tlut_pkg::TBL_W-1:0] tbl,
  output logic [W-1:0]              y
);
  import tlut_pkg::*;

  logic [IDX_W-1:0] idx;

  assign idx = {|a, |b, |c};

  always_comb begin
    y    = '0;
    y[0] = tbl[idx];
  end
endmodule

// File: rtl/tlut_unit.sv
module tlut_unit #(
  parameter int WIDTH  = 64,
  parameter int IMM_LO = 5,
  parameter int IMM_HI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WIDTH-1:0]  opd_a,
  input  logic [WIDTH-1:0]  opd_b,
  input  logic [WIDTH-1:0]  opd_c,
  input  logic [IMM_LO-1:0] imm_lo,
  input  logic [IMM_HI-1:0] imm_hi,
  input  logic [WIDTH-1:0]  tbl_reg,
  input  logic              tbl_from_reg,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic [WIDTH-1:0]  result
);
  import tlut_pkg::*;

  localparam int TW = IMM_LO + IMM_HI;

  // reset: asserted at once, removed on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [TW-1:0]    tbl;
  logic [WIDTH-1:0] bit_res;
  logic [WIDTH-1:0] word_res;
  lut_mode_e        mode_e;

  assign mode_e = lut_mode_e'(mode);

  tlut_table_sel #(.REG_W(WIDTH), .LO_W(IMM_LO), .HI_W(IMM_HI)) u_tsel (
    .imm_lo   (imm_lo),
    .imm_hi   (imm_hi),
    .tbl_reg  (tbl_reg),
    .from_reg (tbl_from_reg),
    .table_o  (tbl)
  );

  tlut_bitwise #(.W(WIDTH)) u_bits (
    .a(opd_a), .b(opd_b), .c(opd_c), .tbl(tbl), .y(bit_res)
  );

  tlut_wordtest #(.W(WIDTH)) u_word (
    .a(opd_a), .b(opd_b), .c(opd_c), .tbl(tbl), .y(word_res)
  );

  logic [WIDTH-1:0] res_d, res_q;
  logic             vld_d, vld_q;
  logic             res_en;

  always_comb begin
    vld_d  = in_valid;
    res_en = in_valid;
    unique case (mode_e)
      LM_WORD: res_d = word_res;
      default: res_d = bit_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R7
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(result)); // R8
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && mode == 2'd1) |=> (result[WIDTH-1:1] == '0)); // R4
  AST_ONES_PICK_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && mode != 2'd1 && (&opd_a) && (&opd_b) && (&opd_c))
      |=> (result == {WIDTH{$past(tbl[TW-1])}})); // R1
  AST_ZEROS_PICK_IMM0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !tbl_from_reg && mode != 2'd1 && opd_a == '0 && opd_b == '0 && opd_c == '0)
      |=> (result == {WIDTH{$past(imm_lo[0])}})); // R2
endmodule

// File: tb/sim_tlut_unit.sv
module sim_tlut_unit;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] opd_a, opd_b, opd_c, tbl_reg;
  logic [4:0]   imm_lo;
  logic [2:0]   imm_hi;
  logic         tbl_from_reg;
  logic [1:0]   mode;
  logic         out_valid;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlut_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opd_a(opd_a), .opd_b(opd_b), .opd_c(opd_c),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .tbl_reg(tbl_reg),
    .tbl_from_reg(tbl_from_reg), .mode(mode),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, c,
                                         input logic [7:0] t, input logic [1:0] m);
    logic [W-1:0] r;
    int k;
    r = '0;
    if (m == 2'd1) begin
      k = (a != 0 ? 4 : 0) + (b != 0 ? 2 : 0) + (c != 0 ? 1 : 0);
      r[0] = t[k];
    end else begin
      for (int i = 0; i < W; i++) begin
        k = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
        r[i] = t[k];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation, then sample after the registering edge
  task automatic run_op(input string req, input logic [W-1:0] a, b, c,
                        input logic [7:0] t, input logic use_reg,
                        input logic [W-1:0] hi_junk, input logic [1:0] m);
    @(negedge clk);
    in_valid     = 1'b1;
    opd_a        = a;
    opd_b        = b;
    opd_c        = c;
    imm_lo       = t[4:0];
    imm_hi       = t[7:5];
    tbl_from_reg = use_reg;
    tbl_reg      = use_reg ? {hi_junk[W-1:8], t} : rnd64();
    if (use_reg) begin
      imm_lo = 5'($urandom);
      imm_hi = 3'($urandom);
    end
    mode = m;
    @(posedge clk);
    #2;
    check(req, result, model(a, b, c, t, m));
    check("R7", {63'b0, out_valid}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [W-1:0] a, b, c, held;
    rst_n = 1'b0; in_valid = 1'b0; opd_a = '0; opd_b = '0; opd_c = '0;
    imm_lo = '0; imm_hi = '0; tbl_reg = '0; tbl_from_reg = 1'b0; mode = 2'd0;
    repeat (4) @(posedge clk);
    #2;
    check("R9", result, '0);
    check("R9", {63'b0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 R2 R3: every table, immediate and register sources
    for (int t = 0; t < 256; t++) begin
      for (int p = 0; p < 5; p++) begin
        case (p)
          0: begin a = '0; b = '0; c = '0; end
          1: begin a = '1; b = '1; c = '1; end
          2, 3: begin a = rnd64(); b = rnd64(); c = rnd64(); end
          default: begin a = '1; b = rnd64(); c = '0; end
        endcase
        run_op("R1/R2", a, b, c, 8'(t), 1'b0, '0, 2'd0);
        run_op("R3", a, b, c, 8'(t), 1'b1, rnd64(), 2'd0);
      end
    end

    // R4: every table with each zero/nonzero combination
    for (int t = 0; t < 256; t++) begin
      for (int k = 0; k < 8; k++) begin
        a = k[2] ? (64'd1 << ($urandom % 64)) : '0;
        b = k[1] ? (64'd1 << ($urandom % 64)) : '0;
        c = k[0] ? (64'd1 << ($urandom % 64)) : '0;
        run_op("R4", a, b, c, 8'(t), t[0], rnd64(), 2'd1);
      end
    end

    // R5: reserved modes match bitwise
    for (int t = 0; t < 256; t += 3) begin
      a = rnd64(); b = rnd64(); c = rnd64();
      run_op("R5", a, b, c, 8'(t), 1'b0, '0, 2'd2);
      run_op("R5", a, b, c, 8'(t), 1'b1, rnd64(), 2'd3);
    end

    // R6: conditional mix via 0xD8
    for (int n = 0; n < 8; n++) begin
      a = rnd64(); b = rnd64(); c = rnd64();
      run_op("R6", a, b, c, 8'hD8, 1'b0, '0, 2'd0);
      check("R6", result, (b & c) | (a & ~c));
    end

    // R7 R8: idle cycles with moving inputs
    held = result;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opd_a = rnd64(); opd_b = rnd64(); opd_c = rnd64();
      imm_lo = 5'($urandom); imm_hi = 3'($urandom);
      mode = 2'($urandom);
      @(posedge clk);
      #2;
      check("R8", result, held);
      check("R7", {63'b0, out_valid}, 64'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule